// File: doc/BRIEF.md
# Bus-Side Real-Time Clock with Coherent Seconds Capture

This block keeps wall-clock time for a chip. A slow tick input, one pulse per period of a 32.768 kHz reference already brought into the bus clock domain, drives an internal milliseconds counter through a fractional accumulator. The milliseconds counter carries into a 32-bit seconds counter. Software never reads these counters directly. A small copy machine publishes them to a pair of bus-side registers. It has two states. In `CP_RUN` the busy flag is low and the bus-side values hold. On every eighth tick the machine takes the transition *run-to-copy* into `CP_COPY`. The busy flag stays high for `COPY_CYCLES` bus-clock cycles. The machine then takes the transition *copy-to-run* and publishes seconds and milliseconds together on the same edge.

Reading the milliseconds register copies the published seconds into a shadow register. A read of milliseconds followed by a read of the shadow therefore gives a matching pair. Two seconds alarms and one milliseconds alarm compare against the counters as they advance, and each sets its own bit in a write-one-to-clear status register. A mask register selects which status bits drive the level-high interrupt output. Writes to the seconds, alarm and mask registers are dropped while the busy flag is high, so software should wait for busy to fall and then write during the quiet gap that follows.

Top module: `rtc_bus_top`

## Requirements
- R1: After reset every register reads zero, the busy flag is low and `irq_o` is low.
- R2: Each tick adds 1000 to an accumulator. When the accumulator reaches `TICK_HZ`, `TICK_HZ` is subtracted from it and milliseconds advance by one. Milliseconds wrap from 999 to 0, and each wrap increments seconds, which wrap modulo 2^32.
- R3: On every eighth tick after reset, bit 0 of offset 0x004 reads 1 for `COPY_CYCLES` cycles. Seconds (0x008) and milliseconds (0x010) then update together to the counter values and hold until the next window.
- R4: A read of 0x010 loads the shadow register at 0x00C with the currently published seconds.
- R5: A write to seconds, either seconds alarm, the milliseconds alarm or the mask while busy reads 1 is ignored.
- R6: A write to 0x008 while not busy sets the time at once. It reads back immediately, and counting continues from the written value without disturbing milliseconds.
- R7: Seconds alarm 0 (0x014) and seconds alarm 1 (0x018) set status bit 0 and bit 1 respectively when seconds step onto the alarm value. An alarm value of zero never fires.
- R8: The milliseconds alarm (0x01C, 10 bits) sets status bit 2 when milliseconds step onto its value. A value of zero never fires.
- R9: Status (0x02C) is write-one-to-clear and may be written at any time. A 1 clears the bit, a 0 leaves it as it is, and writing 0xFFFFFFFF clears all bits. A new event in the same cycle wins over the clear.
- R10: Status bits are set regardless of the mask (0x028). `irq_o` is high exactly while some status bit and the same mask bit are both 1.
- R11: Mask and status are 5 bits wide: bits 0 to 2 as above, bits 3 and 4 reserved for countdown sources and never set. Upper bits read 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions assume three things about the inputs: tick pulses last one cycle, every bus access lasts one cycle, and reset is held from time zero. They also assume the copy window ends before the next tick, so no tick arrives while busy is high. The bench drives ticks eight bus cycles apart with a four-cycle window, so each window closes well before the next tick. Writes meant to take effect are issued in the gaps between windows. Writes that must be ignored are placed deliberately inside a busy window. Random time values, alarm values and clear patterns are drawn from a fixed seed and checked against a bench-side model of the counters, the publishing and the status bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned NSRC = 5;

    localparam logic [7:0] OFS_BUSY   = 8'h04;
    localparam logic [7:0] OFS_SEC    = 8'h08;
    localparam logic [7:0] OFS_SHADOW = 8'h0C;
    localparam logic [7:0] OFS_MSEC   = 8'h10;
    localparam logic [7:0] OFS_SALM0  = 8'h14;
    localparam logic [7:0] OFS_MALM   = 8'h1C;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STAT   = 8'h2C;

    typedef enum logic {
        CP_RUN  = 1'b0,
        CP_COPY = 1'b1
    } copy_state_e;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int unsigned TICK_HZ    = 32768,
    parameter int unsigned MS_PER_SEC = 1000,
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_val_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [MS_W-1:0]  ms_o,
    output logic             sec_adv_o,
    output logic             ms_adv_o
);
    localparam int unsigned ACC_W = $clog2(TICK_HZ + MS_PER_SEC);
    localparam logic [ACC_W:0] K_INC = (ACC_W+1)'(MS_PER_SEC);
    localparam logic [ACC_W:0] K_HZ  = (ACC_W+1)'(TICK_HZ);
    localparam logic [MS_W-1:0] K_MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;
    logic [ACC_W:0]   acc_wrap;
    logic             ms_step;
    logic             ms_last;

    always_comb begin
        acc_sum  = {1'b0, acc_q} + K_INC;
        acc_wrap = acc_sum - K_HZ;
        ms_step  = (acc_sum >= K_HZ);
        ms_last  = (ms_o == K_MS_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            ms_o      <= '0;
            sec_o     <= '0;
            ms_adv_o  <= 1'b0;
            sec_adv_o <= 1'b0;
        end else begin
            ms_adv_o  <= 1'b0;
            sec_adv_o <= 1'b0;
            if (tick_i) begin
                acc_q <= ms_step ? acc_wrap[ACC_W-1:0] : acc_sum[ACC_W-1:0];
                if (ms_step) begin
                    ms_adv_o <= 1'b1;
                    if (ms_last) begin
                        ms_o      <= '0;
                        sec_o     <= sec_o + 1'b1;
                        sec_adv_o <= !load_i;
                    end else begin
                        ms_o <= ms_o + 1'b1;
                    end
                end
            end
            if (load_i) begin
                sec_o <= load_val_i;
            end
        end
    end

    // R2: milliseconds never leave their range
    a_r2_ms_bound: assert property (@(posedge clk) disable iff (rst)
        ms_o < MS_W'(MS_PER_SEC));

    // R2: a seconds step comes with a milliseconds wrap and adds exactly one
    a_r2_carry: assert property (@(posedge clk) disable iff (rst)
        sec_adv_o |-> (ms_o == '0) && (sec_o == $past(sec_o) + 1'b1));

    // R2: milliseconds only move on a tick
    a_r2_ms_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_i) |-> $stable(ms_o));
endmodule

// File: rtl/rtc_copy_fsm.sv
module rtc_copy_fsm
    import rtc_pkg::*;
#(
    parameter int unsigned COPY_EVERY  = 8,
    parameter int unsigned COPY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic busy_o,
    output logic publish_o
);
    localparam int unsigned TC_W = (COPY_EVERY > 1) ? $clog2(COPY_EVERY) : 1;
    localparam int unsigned CC_W = (COPY_CYCLES > 1) ? $clog2(COPY_CYCLES) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(COPY_EVERY - 1);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(COPY_CYCLES - 1);

    copy_state_e state_q, state_d;
    logic [TC_W-1:0] tick_cnt_q;
    logic [CC_W-1:0] cyc_cnt_q;
    logic            window_tick;
    logic            window_done;

    assign window_tick = tick_i && (tick_cnt_q == TC_LAST);
    assign window_done = (cyc_cnt_q == CC_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CP_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt_q <= '0;
            cyc_cnt_q  <= '0;
        end else begin
            if (tick_i) begin
                tick_cnt_q <= (tick_cnt_q == TC_LAST) ? '0 : tick_cnt_q + 1'b1;
            end
            if (state_q == CP_COPY) begin
                cyc_cnt_q <= window_done ? '0 : cyc_cnt_q + 1'b1;
            end else begin
                cyc_cnt_q <= '0;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        busy_o    = 1'b0;
        publish_o = 1'b0;
        unique case (state_q)
            CP_RUN: begin
                if (window_tick) begin
                    state_d = CP_COPY;
                end
            end
            CP_COPY: begin
                busy_o = 1'b1;
                if (window_done) begin
                    publish_o = 1'b1;
                    state_d   = CP_RUN;
                end
            end
            default: state_d = CP_RUN;
        endcase
    end

    // R3: a copy window opens only on a tick
    a_r3_open_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(tick_i));

    // R3: publishing closes the window
    a_r3_publish_closes: assert property (@(posedge clk) disable iff (rst)
        publish_o |=> !busy_o);

    // R3: the window stays open until it publishes
    a_r3_window_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !publish_o) |=> busy_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
#(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned MS_W  = 10,
    parameter int unsigned N_SALM = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SEC_W-1:0]            sec_i,
    input  logic                        sec_adv_i,
    input  logic [MS_W-1:0]             ms_i,
    input  logic                        ms_adv_i,
    input  logic [N_SALM-1:0][SEC_W-1:0] salm_i,
    input  logic [MS_W-1:0]             malm_i,
    input  logic [NSRC-1:0]             clr_i,
    input  logic [NSRC-1:0]             mask_i,
    output logic [NSRC-1:0]             status_o,
    output logic                        irq_o
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < N_SALM; g++) begin : g_salm
        assign hit[g] = sec_adv_i && (salm_i[g] != '0) && (sec_i == salm_i[g]);
    end

    assign hit[N_SALM] = ms_adv_i && (malm_i != '0) && (ms_i == malm_i);

    for (genvar g = N_SALM + 1; g < NSRC; g++) begin : g_rsvd
        assign hit[g] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
        end else begin
            status_o <= (status_o & ~clr_i) | hit;
        end
    end

    assign irq_o = |(status_o & mask_i);

    // R9: a clear without a new event empties the bit
    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr_i[0] && !hit[0]) |=> !status_o[0]);

    // R9: a pending bit stays until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_o[1] && !clr_i[1]) |=> status_o[1]);

    // R7: a zero alarm never raises its bit
    a_r7_zero_alarm: assert property (@(posedge clk) disable iff (rst)
        (salm_i[0] == '0) |=> !$rose(status_o[0]));

    // R11: reserved countdown bits never set
    a_r11_rsvd_quiet: assert property (@(posedge clk) disable iff (rst)
        status_o[NSRC-1:N_SALM+1] == '0);
endmodule

// File: rtl/rtc_bus_top.sv
module rtc_bus_top
    import rtc_pkg::*;
#(
    parameter int unsigned TICK_HZ     = 32768,
    parameter int unsigned MS_PER_SEC  = 1000,
    parameter int unsigned COPY_EVERY  = 8,
    parameter int unsigned COPY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o
);
    localparam int unsigned SEC_W  = 32;
    localparam int unsigned MS_W   = $clog2(MS_PER_SEC);
    localparam int unsigned N_SALM = 2;

    logic             busy;
    logic             publish;
    logic [SEC_W-1:0] core_sec;
    logic [MS_W-1:0]  core_ms;
    logic             sec_adv;
    logic             ms_adv;

    logic [SEC_W-1:0] sec_pub_q;
    logic [MS_W-1:0]  ms_pub_q;
    logic [SEC_W-1:0] shadow_q;
    logic [N_SALM-1:0][SEC_W-1:0] salm_q;
    logic [MS_W-1:0]  malm_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  status;
    logic [NSRC-1:0]  clr;

    logic wr_any, wr_ok, rd_any;
    logic wr_sec, wr_malm, wr_mask, rd_msec;
    logic [N_SALM-1:0] wr_salm;

    assign wr_any  = bus_sel_i && bus_wr_i;
    assign rd_any  = bus_sel_i && !bus_wr_i;
    assign wr_ok   = wr_any && !busy;
    assign wr_sec  = wr_ok && (bus_addr_i == OFS_SEC);
    assign wr_malm = wr_ok && (bus_addr_i == OFS_MALM);
    assign wr_mask = wr_ok && (bus_addr_i == OFS_MASK);
    assign rd_msec = rd_any && (bus_addr_i == OFS_MSEC);
    assign clr     = (wr_any && (bus_addr_i == OFS_STAT)) ? bus_wdata_i[NSRC-1:0] : '0;

    for (genvar g = 0; g < N_SALM; g++) begin : g_salm_dec
        localparam logic [7:0] OFS_G = OFS_SALM0 + 8'(4 * g);
        assign wr_salm[g] = wr_ok && (bus_addr_i == OFS_G);
    end

    rtc_time_core #(
        .TICK_HZ   (TICK_HZ),
        .MS_PER_SEC(MS_PER_SEC),
        .SEC_W     (SEC_W),
        .MS_W      (MS_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .load_i    (wr_sec),
        .load_val_i(bus_wdata_i),
        .sec_o     (core_sec),
        .ms_o      (core_ms),
        .sec_adv_o (sec_adv),
        .ms_adv_o  (ms_adv)
    );

    rtc_copy_fsm #(
        .COPY_EVERY (COPY_EVERY),
        .COPY_CYCLES(COPY_CYCLES)
    ) u_copy (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .busy_o   (busy),
        .publish_o(publish)
    );

    rtc_irq_ctrl #(
        .SEC_W (SEC_W),
        .MS_W  (MS_W),
        .N_SALM(N_SALM)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .sec_i    (core_sec),
        .sec_adv_i(sec_adv),
        .ms_i     (core_ms),
        .ms_adv_i (ms_adv),
        .salm_i   (salm_q),
        .malm_i   (malm_q),
        .clr_i    (clr),
        .mask_i   (mask_q),
        .status_o (status),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_pub_q <= '0;
            ms_pub_q  <= '0;
            shadow_q  <= '0;
            salm_q    <= '0;
            malm_q    <= '0;
            mask_q    <= '0;
        end else begin
            if (publish) begin
                sec_pub_q <= core_sec;
                ms_pub_q  <= core_ms;
            end
            if (wr_sec) begin
                sec_pub_q <= bus_wdata_i;
            end
            for (int i = 0; i < N_SALM; i++) begin
                if (wr_salm[i]) begin
                    salm_q[i] <= bus_wdata_i;
                end
            end
            if (wr_malm) begin
                malm_q <= bus_wdata_i[MS_W-1:0];
            end
            if (wr_mask) begin
                mask_q <= bus_wdata_i[NSRC-1:0];
            end
            if (rd_msec) begin
                shadow_q <= sec_pub_q;
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_BUSY:      bus_rdata_o = {31'b0, busy};
            OFS_SEC:       bus_rdata_o = sec_pub_q;
            OFS_SHADOW:    bus_rdata_o = shadow_q;
            OFS_MSEC:      bus_rdata_o = 32'(ms_pub_q);
            OFS_SALM0:     bus_rdata_o = salm_q[0];
            OFS_SALM0 + 8'h04: bus_rdata_o = salm_q[1];
            OFS_MALM:      bus_rdata_o = 32'(malm_q);
            OFS_MASK:      bus_rdata_o = 32'(mask_q);
            OFS_STAT:      bus_rdata_o = 32'(status);
            default:       bus_rdata_o = '0;
        endcase
    end

    // R5: an alarm write during a copy window leaves the alarm alone
    a_r5_busy_blocks_alarm: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_any && (bus_addr_i == OFS_SALM0)) |=> (salm_q[0] == $past(salm_q[0])));

    // R5: a mask write during a copy window leaves the mask alone
    a_r5_busy_blocks_mask: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_any && (bus_addr_i == OFS_MASK)) |=> $stable(mask_q));

    // R4: a milliseconds read captures the published seconds
    a_r4_shadow_capture: assert property (@(posedge clk) disable iff (rst)
        rd_msec |=> (shadow_q == $past(sec_pub_q)));

    // R3: published values move only on publish or a time write
    a_r3_pub_hold: assert property (@(posedge clk) disable iff (rst)
        (!publish && !wr_sec) |=> ($stable(sec_pub_q) && $stable(ms_pub_q)));
endmodule

// File: tb/rtc_bus_top_tb_top.sv
module rtc_bus_top_tb_top;
    import rtc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 1250;
    localparam int MSPS       = 1000;
    localparam int WIN_EVERY  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bus_top #(
        .TICK_HZ    (HZ),
        .MS_PER_SEC (MSPS),
        .COPY_EVERY (WIN_EVERY),
        .COPY_CYCLES(4)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .bus_sel_i  (sel),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] sec_e = '0, pub_sec = '0, shadow_e = '0, a0_e = '0, a1_e = '0;
    int          ms_e = 0, pub_ms = 0, acc_e = 0, ma_e = 0, ticks_total = 0;
    logic [4:0]  st_e = '0, mask_e = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    function automatic void model_tick();
        acc_e += MSPS;
        if (acc_e >= HZ) begin
            acc_e -= HZ;
            if (ms_e == MSPS - 1) begin
                ms_e = 0;
                sec_e = sec_e + 1;
                if (a0_e != 0 && sec_e == a0_e) st_e[0] = 1'b1;
                if (a1_e != 0 && sec_e == a1_e) st_e[1] = 1'b1;
            end else begin
                ms_e++;
                if (ma_e != 0 && ms_e == ma_e) st_e[2] = 1'b1;
            end
        end
        ticks_total++;
        if (ticks_total % WIN_EVERY == 0) begin
            pub_sec = sec_e;
            pub_ms  = ms_e;
        end
    endfunction

    task automatic do_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        repeat (7) @(negedge clk);
        model_tick();
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        bus_rd(OFS_SEC, d);
        chk({tag, " R3 published seconds"}, d, pub_sec);
        bus_rd(OFS_MSEC, d);
        chk({tag, " R2 published milliseconds"}, d, 32'(pub_ms));
        shadow_e = pub_sec;
        bus_rd(OFS_SHADOW, d);
        chk({tag, " R4 shadow seconds"}, d, shadow_e);
        bus_rd(OFS_STAT, d);
        chk({tag, " R7/R8 status"}, d, 32'(st_e));
        chk({tag, " R10 irq level"}, 32'(irq), 32'(|(st_e & mask_e)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        logic [7:0] ofs [10];
        ofs = '{OFS_BUSY, OFS_SEC, OFS_SHADOW, OFS_MSEC, OFS_SALM0, 8'h18,
                OFS_MALM, OFS_MASK, OFS_STAT, 8'h20};
        r = $urandom(32'd20240611);

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 and R11: reset state, unmapped offset reads zero
        foreach (ofs[i]) begin
            bus_rd(ofs[i], d);
            chk($sformatf("R1 reset value at %h", ofs[i]), d, 32'h0);
        end
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2: accumulator-driven milliseconds
        run_ticks(16);
        check_regs("first windows");
        run_ticks(13);
        bus_rd(OFS_MSEC, d);
        chk("R3 milliseconds hold between windows", d, 32'(pub_ms));
        run_ticks(3);

        // R6: time write readable at once, counting continues
        bus_wr(OFS_SEC, 32'h1234_5678);
        sec_e = 32'h1234_5678; pub_sec = sec_e;
        bus_rd(OFS_SEC, d);
        chk("R6 seconds readback", d, 32'h1234_5678);
        run_ticks(24);
        check_regs("after time write");

        // R11: mask width
        bus_wr(OFS_MASK, 32'hFFFF_FFFF);
        mask_e = 5'h1F;
        bus_rd(OFS_MASK, d);
        chk("R11 mask width", d, 32'h1F);
        bus_wr(OFS_MASK, 32'h0);
        mask_e = '0;

        // R3 and R5: writes inside a copy window are dropped
        while (ticks_total % WIN_EVERY != WIN_EVERY - 1) do_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        bus_rd(OFS_BUSY, d);
        chk("R3 busy high in window", d, 32'h1);
        bus_wr(OFS_SALM0, 32'hDEAD_0001);
        bus_wr(OFS_SEC, 32'hDEAD_0002);
        bus_wr(OFS_MASK, 32'h1F);
        repeat (4) @(negedge clk);
        bus_rd(OFS_BUSY, d);
        chk("R3 busy low after window", d, 32'h0);
        bus_rd(OFS_SALM0, d);
        chk("R5 alarm write ignored while busy", d, 32'h0);
        bus_rd(OFS_MASK, d);
        chk("R5 mask write ignored while busy", d, 32'h0);
        bus_rd(OFS_SEC, d);
        chk("R5 seconds write ignored while busy", d, pub_sec);

        // R7: alarm 1 fires at FFFFFFFF, zero alarm 0 silent across wrap to 0
        bus_wr(OFS_SEC, 32'hFFFF_FFFE);
        sec_e = 32'hFFFF_FFFE; pub_sec = sec_e;
        bus_wr(8'h18, 32'hFFFF_FFFF);
        a1_e = 32'hFFFF_FFFF;
        bus_wr(OFS_MASK, 32'h2);
        mask_e = 5'h2;
        for (int g = 0; g < 6000 && !(sec_e == 0 && ticks_total % WIN_EVERY == 0); g++) do_tick();
        check_regs("R7 wrap and alarm 1");
        chk("R2 seconds wrapped to zero", pub_sec, 32'h0);
        chk("R7 zero alarm 0 silent", 32'(st_e[0]), 32'h0);

        // R9: zero write keeps, one write clears
        bus_wr(OFS_STAT, 32'h0);
        bus_rd(OFS_STAT, d);
        chk("R9 zero write keeps status", d, 32'(st_e));
        bus_wr(OFS_STAT, 32'hFFFF_FFFF);
        st_e = '0;
        bus_rd(OFS_STAT, d);
        chk("R9 all-ones clears status", d, 32'h0);
        chk("R10 irq falls after clear", 32'(irq), 32'h0);

        // R8 and R10: milliseconds alarm with mask off, then on
        ma_e = (ms_e + 7) % MSPS;
        if (ma_e == 0) ma_e = 1;
        bus_wr(OFS_MALM, 32'(ma_e));
        run_ticks(16);
        check_regs("R8 masked ms alarm");
        bus_wr(OFS_MASK, 32'h4);
        mask_e = 5'h4;
        chk("R10 irq follows mask", 32'(irq), 32'(|(st_e & mask_e)));
        bus_wr(OFS_STAT, 32'h4);
        st_e[2] = 1'b0;
        chk("R9 single-bit clear", 32'(irq), 32'h0);

        // random phase
        for (int it = 0; it < 40; it++) begin
            int n;
            int op;
            n  = 1 + int'($urandom % 30);
            op = int'($urandom % 6);
            run_ticks(n);
            case (op)
                0: begin
                    d = $urandom;
                    bus_wr(OFS_SEC, d);
                    sec_e = d; pub_sec = d;
                end
                1: begin
                    d = ($urandom % 2 == 0) ? sec_e + 1 : 32'h0;
                    bus_wr(OFS_SALM0, d);
                    a0_e = d;
                end
                2: begin
                    ma_e = int'($urandom % MSPS);
                    bus_wr(OFS_MALM, 32'(ma_e));
                end
                3: begin
                    d = $urandom;
                    bus_wr(OFS_STAT, d);
                    st_e = st_e & ~d[4:0];
                end
                4: begin
                    d = $urandom;
                    bus_wr(OFS_MASK, d);
                    mask_e = d[4:0];
                end
                default: begin
                    bus_wr(OFS_SEC, sec_e | 32'h0000_0000);
                    pub_sec = sec_e;
                end
            endcase
            check_regs($sformatf("random %0d", it));
        end

        done = 1'b1;
        finish_up();
    end
endmodule